// File: doc/BRIEF.md
# Dual-Channel Sinc3 Decimator with Selectable Word Rate

This block turns two single-bit delta-sigma streams into 16-bit signed samples. One stream carries a voltage measurement and the other a current measurement. Each stream passes through a third-order comb (sinc3) decimator with response ((1 - z^-N)/(1 - z^-1))^3. Both channels share one sampling cadence and one decimation counter, so each pair of output words describes the same instant. The block also paces the external modulators: it asserts `bit_take` once every eight clocks, and both input bits are captured on that clock edge.

A single rate input switches both channels together. Low selects N = 256, which gives one output pair every 2048 clocks. High selects N = 128, which gives one pair every 1024 clocks. The wide filter result is cut to 16 bits by an arithmetic right shift whose length follows the selected ratio, so a stream of all ones gives the top code and a stream of all zeros gives the bottom code at either rate. Values past the 16-bit range are clamped.

After reset, and after any change of the rate input, the first three filter results are dropped while the comb delay line refills. Only the fourth and later results are published with `word_valid`.

Top module: `sinc3_dual_decim`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `word_valid` is 0 and both output words are 0.
- R2: `bit_take` is high for one clock in every 8 clocks, and both input bits are captured on the clock edge at the end of that cycle.
- R3: In steady operation, successive `word_valid` pulses are 2048 clocks apart with `rate_sel` = 0 and 1024 clocks apart with `rate_sel` = 1.
- R4: Input bit 1 counts as +1 and bit 0 as -1. A steady all-ones stream settles to 0x7FFF (the clamped value of +32768), and a steady all-zeros stream settles to 0x8000, at both rates.
- R5: A steady 16-bit periodic stream containing k ones settles to the two's-complement value min(2048*(2k-16), 32767), at both rates.
- R6: The two channels filter independently, and both output words change on the same clock edge that raises `word_valid`.
- R7: After reset is released, the first `word_valid` arrives on the fourth decimation event, about 4*N*8 clocks later.
- R8: After `rate_sel` changes, the next three decimation events at the new ratio are not published, and the first `word_valid` comes about 4*N*8 clocks after the change.
- R9: Both output words hold their value in every cycle where `word_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 0: decimate by 256, 1: decimate by 128 |
| v_bit | input | 1 | Voltage modulator bit |
| i_bit | input | 1 | Current modulator bit |
| bit_take | output | 1 | High in the cycle whose closing edge captures both bits |
| v_word | output | 16 | Voltage sample, two's complement |
| i_word | output | 16 | Current sample, two's complement |
| word_valid | output | 1 | One-clock pulse marking a new published sample pair |

## Verification
The hardest case to reach from the ports is the recovery after a rate change. There, the comb delay line still holds integrator snapshots taken at the old spacing, and any published word that mixes the two spacings is wrong. The stimulus keeps a periodic pattern running across each switch and measures how long the first `word_valid` takes to arrive. It then checks the values that follow against the level expected from the bit density. Random densities with one-bits in random positions, repeating every 16 bits so the expected value is exact at either ratio, are mixed with directed all-ones, all-zeros and alternating streams.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  // Accumulator bits needed to hold +/-N^3 without losing the sign bit.
  function automatic int acc_width(input int n);
    return 3 * $clog2(n) + 2;
  endfunction

  // Right shift that moves N^3 onto 2^(ow-1).
  function automatic int shift_for(input int n, input int ow);
    return 3 * $clog2(n) - (ow - 1);
  endfunction

endpackage

// File: rtl/sinc3_tick_gen.sv
module sinc3_tick_gen #(
  parameter int DIV    = 8,
  parameter int N_SLOW = 256,
  parameter int N_FAST = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  output logic bit_take,
  output logic dec_ev,
  output logic rate_fast,
  output logic restart
);
  import sinc3_pkg::*;

  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(N_SLOW);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  rate_e            rate_q;
  logic             take_q;
  logic             dec_q;
  logic             restart_q;
  logic             changed;

  assign changed  = (rate_sel != rate_q);
  assign last_idx = (rate_q == RATE_FAST) ? CNT_W'(N_FAST - 1) : CNT_W'(N_SLOW - 1);

  // Divider that paces the modulator bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      take_q <= 1'b0;
    end else begin
      div_q  <= (div_q == DIV_W'(DIV - 1)) ? '0 : div_q + 1'b1;
      take_q <= (div_q == DIV_W'(DIV - 2));
    end
  end

  // Decimation counter; it restarts when the ratio changes.
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q    <= RATE_SLOW;
      cnt_q     <= '0;
      dec_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      rate_q    <= rate_e'(rate_sel);
      restart_q <= changed;
      if (changed) begin
        cnt_q <= '0;
        dec_q <= 1'b0;
      end else if (take_q) begin
        if (cnt_q == last_idx) begin
          cnt_q <= '0;
          dec_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          dec_q <= 1'b0;
        end
      end else begin
        dec_q <= 1'b0;
      end
    end
  end

  assign bit_take  = take_q;
  assign dec_ev    = dec_q;
  assign rate_fast = (rate_q == RATE_FAST);
  assign restart   = restart_q;

endmodule

// File: rtl/sinc3_settle.sv
module sinc3_settle #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic dec_ev,
  output logic publish
);
  localparam int SC_W = $clog2(SETTLE + 1);

  logic [SC_W-1:0] seen_q;
  logic            done;

  assign done    = (seen_q == SC_W'(SETTLE));
  assign publish = dec_ev && done && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      seen_q <= '0;
    end else if (dec_ev && !done) begin
      seen_q <= seen_q + 1'b1;
    end
  end

endmodule

// File: rtl/sinc3_chan.sv
module sinc3_chan #(
  parameter int ACC_W   = 26,
  parameter int OUT_W   = 16,
  parameter int SH_SLOW = 9,
  parameter int SH_FAST = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             take,
  input  logic             dec_ev,
  input  logic             publish,
  input  logic             rate_fast,
  output logic [OUT_W-1:0] word
);
  localparam logic signed [ACC_W-1:0] MAX_POS = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_NEG = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] step;
  logic signed [ACC_W-1:0] int1_q, int2_q, int3_q;
  logic signed [ACC_W-1:0] dly1_q, dly2_q, dly3_q;
  logic signed [ACC_W-1:0] cmb1, cmb2, cmb3;
  logic signed [ACC_W-1:0] scaled;
  logic        [OUT_W-1:0] clamped;
  logic        [OUT_W-1:0] word_q;

  assign step = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  // Comb section evaluated on the decimated sample.
  always_comb begin
    cmb1   = int3_q - dly1_q;
    cmb2   = cmb1 - dly2_q;
    cmb3   = cmb2 - dly3_q;
    scaled = rate_fast ? (cmb3 >>> SH_FAST) : (cmb3 >>> SH_SLOW);
    if (scaled > MAX_POS) begin
      clamped = {1'b0, {(OUT_W-1){1'b1}}};
    end else if (scaled < MIN_NEG) begin
      clamped = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      clamped = scaled[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int1_q <= '0;
      int2_q <= '0;
      int3_q <= '0;
      dly1_q <= '0;
      dly2_q <= '0;
      dly3_q <= '0;
      word_q <= '0;
    end else begin
      if (take) begin
        int1_q <= int1_q + step;
        int2_q <= int2_q + int1_q;
        int3_q <= int3_q + int2_q;
      end
      if (dec_ev) begin
        dly1_q <= int3_q;
        dly2_q <= cmb1;
        dly3_q <= cmb2;
      end
      if (publish) begin
        word_q <= clamped;
      end
    end
  end

  assign word = word_q;

endmodule

// File: rtl/sinc3_dual_decim.sv
module sinc3_dual_decim #(
  parameter int DIV    = 8,
  parameter int N_SLOW = 256,
  parameter int N_FAST = 128,
  parameter int OUT_W  = 16,
  parameter int SETTLE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_sel,
  input  logic             v_bit,
  input  logic             i_bit,
  output logic             bit_take,
  output logic [OUT_W-1:0] v_word,
  output logic [OUT_W-1:0] i_word,
  output logic             word_valid
);
  import sinc3_pkg::*;

  localparam int ACC_W   = acc_width(N_SLOW);
  localparam int SH_SLOW = shift_for(N_SLOW, OUT_W);
  localparam int SH_FAST = shift_for(N_FAST, OUT_W);
  localparam int NCH     = 2;

  logic             take;
  logic             dec_ev;
  logic             rate_fast;
  logic             restart;
  logic             publish;
  logic             valid_q;
  logic [NCH-1:0]   bits;
  logic [OUT_W-1:0] words [NCH];

  assign bits = {i_bit, v_bit};

  sinc3_tick_gen #(
    .DIV    (DIV),
    .N_SLOW (N_SLOW),
    .N_FAST (N_FAST)
  ) tick_i (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .bit_take  (take),
    .dec_ev    (dec_ev),
    .rate_fast (rate_fast),
    .restart   (restart)
  );

  sinc3_settle #(
    .SETTLE (SETTLE)
  ) settle_i (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .dec_ev  (dec_ev),
    .publish (publish)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    sinc3_chan #(
      .ACC_W   (ACC_W),
      .OUT_W   (OUT_W),
      .SH_SLOW (SH_SLOW),
      .SH_FAST (SH_FAST)
    ) chan_i (
      .clk       (clk),
      .rst       (rst),
      .bit_in    (bits[ch]),
      .take      (take),
      .dec_ev    (dec_ev),
      .publish   (publish),
      .rate_fast (rate_fast),
      .word      (words[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= publish;
  end

  assign bit_take   = take;
  assign v_word     = words[0];
  assign i_word     = words[1];
  assign word_valid = valid_q;

endmodule

// File: rtl/sinc3_dual_decim_chk.sv
module sinc3_dual_decim_chk #(
  parameter int DIV    = 8,
  parameter int N_SLOW = 256,
  parameter int N_FAST = 128,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rate_sel,
  input logic             bit_take,
  input logic [OUT_W-1:0] v_word,
  input logic [OUT_W-1:0] i_word,
  input logic             word_valid
);
  localparam int P_SLOW = DIV * N_SLOW;
  localparam int P_FAST = DIV * N_FAST;

  logic [7:0]  tgap_q;
  logic [31:0] wgap_q;
  logic        have_prev_q;
  logic        rate_seen_q;
  logic [1:0]  hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgap_q      <= '0;
      wgap_q      <= '0;
      have_prev_q <= 1'b0;
      rate_seen_q <= rate_sel;
      hold_q      <= 2'd0;
    end else begin
      tgap_q <= bit_take ? 8'd0 : tgap_q + 8'd1;
      wgap_q <= word_valid ? 32'd0 : wgap_q + 32'd1;
      if (rate_sel != rate_seen_q) begin
        rate_seen_q <= rate_sel;
        have_prev_q <= 1'b0;
        hold_q      <= 2'd2;
      end else begin
        if (hold_q != 2'd0) hold_q <= hold_q - 2'd1;
        if (word_valid && hold_q == 2'd0) have_prev_q <= 1'b1;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !word_valid);

  // R2
  take_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    bit_take |-> (tgap_q == 8'(DIV - 1)));

  // R3
  word_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && have_prev_q && rate_sel == rate_seen_q) |->
      (wgap_q == 32'((rate_seen_q ? P_FAST : P_SLOW) - 1)));

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> ($stable(v_word) && $stable(i_word)));

endmodule

bind sinc3_dual_decim sinc3_dual_decim_chk #(
  .DIV    (DIV),
  .N_SLOW (N_SLOW),
  .N_FAST (N_FAST),
  .OUT_W  (OUT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rate_sel   (rate_sel),
  .bit_take   (bit_take),
  .v_word     (v_word),
  .i_word     (i_word),
  .word_valid (word_valid)
);

// File: tb/sinc3_dual_decim_tb_top.sv
`timescale 1ns/1ps
module sinc3_dual_decim_tb_top;
  localparam int NS = 256;
  localparam int NF = 128;

  logic        clk = 1'b0;
  logic        rst;
  logic        rate_sel;
  logic        v_bit;
  logic        i_bit;
  logic        bit_take;
  logic [15:0] v_word;
  logic [15:0] i_word;
  logic        word_valid;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] pv = 16'hAAAA;
  logic [15:0] pi_ = 16'hAAAA;
  int          idx = 0;
  logic        take_seen = 1'b0;

  always #4 clk = ~clk;

  sinc3_dual_decim dut_i (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .v_bit      (v_bit),
    .i_bit      (i_bit),
    .bit_take   (bit_take),
    .v_word     (v_word),
    .i_word     (i_word),
    .word_valid (word_valid)
  );

  // Modulator model: moves to the next pattern bit after each capture.
  initial begin
    v_bit = 1'b0;
    i_bit = 1'b0;
    forever begin
      @(negedge clk);
      if (take_seen) idx = (idx + 1) % 16;
      v_bit = pv[idx];
      i_bit = pi_[idx];
      take_seen = bit_take;
    end
  end

  function automatic int expect_k(input int k);
    int v;
    v = 2048 * (2 * k - 16);
    if (v > 32767) v = 32767;
    return v;
  endfunction

  function automatic logic [15:0] mask_k(input int k);
    logic [15:0] m;
    m = '0;
    while ($countones(m) < k) m[$urandom % 16] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!word_valid);
  endtask

  task automatic measure(input string req, input int kv, input int ki,
                         input logic [15:0] mv, input logic [15:0] mi);
    logic [15:0] hv, hi;
    pv  = mv;
    pi_ = mi;
    repeat (4) wait_valid();
    check({req, " voltage"}, int'($signed(v_word)), expect_k(kv));
    check({req, " current"}, int'($signed(i_word)), expect_k(ki));
    hv = v_word;
    hi = i_word;
    repeat (60) @(negedge clk);
    check("R9 hold between strobes", int'({v_word, i_word}), int'({hv, hi}));
  endtask

  task automatic cycles_to_valid(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!word_valid);
  endtask

  task automatic spacing(input string req, input int exp);
    int n;
    wait_valid();
    cycles_to_valid(n);
    check(req, n, exp);
  endtask

  task automatic switch_rate(input string req, input logic r, input int n_new);
    int n;
    rate_sel = r;
    repeat (2) @(negedge clk);
    cycles_to_valid(n);
    check_range(req, n + 2, 32 * n_new - 12, 32 * n_new + 12);
  endtask

  initial begin
    int n;
    int dummy;
    dummy = $urandom(32'h5EED_0042);
    rst      = 1'b1;
    rate_sel = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 valid in reset", int'(word_valid), 0);
    check("R1 words in reset", int'({v_word, i_word}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 words after release", int'({word_valid, v_word, i_word}), 0);
    cycles_to_valid(n);
    check_range("R7 first strobe after reset", n + 1, 32 * NS - 12, 32 * NS + 12);

    measure("R4 slow all ones", 16, 16, 16'hFFFF, 16'hFFFF);
    measure("R4 slow all zeros", 0, 0, 16'h0000, 16'h0000);
    measure("R5 slow alternating", 8, 8, 16'hAAAA, 16'h5555);
    measure("R6 slow mixed channels", 12, 4, 16'hFFF0, 16'h1111);
    spacing("R3 slow spacing", 8 * NS);

    switch_rate("R8 settle after switch to fast", 1'b1, NF);
    spacing("R3 fast spacing", 8 * NF);
    measure("R4 fast all ones", 16, 0, 16'hFFFF, 16'h0000);
    measure("R4 fast all zeros", 0, 16, 16'h0000, 16'hFFFF);
    for (int t = 0; t < 10; t++) begin
      int kv, ki;
      kv = int'($urandom % 17);
      ki = int'($urandom % 17);
      measure("R5 fast random density", kv, ki, mask_k(kv), mask_k(ki));
    end

    switch_rate("R8 settle after switch to slow", 1'b0, NS);
    measure("R5 slow density 3/13", 3, 13, mask_k(3), mask_k(13));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule